// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one burst command into the list of per-beat byte addresses that a memory-mapped master or slave port needs. A command carries a start address, a transfer-size code, a length code and a burst kind. It is taken on a valid/ready handshake. The block then sends one address per beat on a second valid/ready handshake and marks the final beat.

Three address patterns are produced. The first is a constant address. The second is a linear walk in which only the first beat may be unaligned. The third is a walk that folds back inside a naturally aligned window. The window is as wide as the whole burst. The block moves no data. It only orders addresses and marks the end of each burst. A controller places it between a command queue and the beat datapath.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no command, `cmd_ready` is 1 and `beat_valid` is 0.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance until the cycle after the final beat handshake. A command presented in that interval is not taken and does not change the beats already in progress.
- R3: The first beat appears in the cycle after acceptance and carries the start address unchanged, aligned or not.
- R4: A burst has `cmd_len`+1 beats. `beat_last` is 1 on the final beat only. A burst with `cmd_len`=0 has one beat with `beat_last` set.
- R5: Kind code 2'b00 (fixed): every beat carries the start address.
- R6: Kind code 2'b01 (linear): beat i>0 carries floor(start/B)*B + i*B. Here B = 2**`cmd_size` bytes, and the sum is taken modulo 2**32.
- R7: Kind code 2'b10 (folding) with `cmd_len` of 1, 3, 7 or 15: the window is W = B*(`cmd_len`+1) bytes and its base is floor(start/W)*W. Beat i>0 carries base + ((floor(start/B)*B - base + i*B) mod W).
- R8: Kind code 2'b10 with any other `cmd_len` produces the linear sequence of R6.
- R9: Kind code 2'b11 is reserved and produces the linear sequence of R6.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_last` and `beat_valid` are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_addr | input | 32 | Start byte address |
| cmd_size | input | 3 | Transfer-size code, bytes per beat = 2**code |
| cmd_len | input | 8 | Beat count minus one |
| cmd_kind | input | 2 | Burst kind: 00 fixed, 01 linear, 10 folding, 11 reserved |
| beat_valid | output | 1 | Beat address offered |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | 32 | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
Two events can fall in the same cycle: the final beat handshake of one burst and a new command waiting on `cmd_valid`. The bench keeps a second command asserted throughout a burst, so the two events meet on the last beat. Under R2 that command must stay refused on that edge and be taken exactly one cycle later. A behavioural queue model predicts `cmd_ready` and every beat on every clock.

The second pairing is a stall that lands on the last beat. Random back-pressure is applied to many random commands, so stalls fall on every kind of beat. Each stalled cycle is judged against R10 as well as against the address expected for that beat.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    KIND_FIXED = 2'b00,
    KIND_LINEAR = 2'b01,
    KIND_FOLD = 2'b10,
    KIND_RSVD = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/bag_cmd_decode.sv
module bag_cmd_decode
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int LEN_W = 8
) (
  input  logic [1:0]        kind_in,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [LEN_W-1:0]  len_in,
  output burst_kind_e       kind_eff,
  output logic [ADDR_W-1:0] fold_mask
);
  logic legal_fold_len;

  always_comb begin
    legal_fold_len = (len_in == LEN_W'(1)) || (len_in == LEN_W'(3)) ||
                     (len_in == LEN_W'(7)) || (len_in == LEN_W'(15));
    unique case (kind_in)
      2'b00:   kind_eff = KIND_FIXED;
      2'b10:   kind_eff = legal_fold_len ? KIND_FOLD : KIND_LINEAR;
      default: kind_eff = KIND_LINEAR;
    endcase
    fold_mask = ((ADDR_W'(len_in) + ADDR_W'(1)) << size_in) - ADDR_W'(1);
  end
endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size_code,
  input  burst_kind_e       kind,
  input  logic [ADDR_W-1:0] fold_mask,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] stepped;

  always_comb begin
    step_bytes = ADDR_W'(1) << size_code;
    aligned    = cur_addr & ~(step_bytes - ADDR_W'(1));
    stepped    = aligned + step_bytes;
    unique case (kind)
      KIND_FIXED: nxt_addr = cur_addr;
      KIND_FOLD:  nxt_addr = (cur_addr & ~fold_mask) | (stepped & fold_mask);
      default:    nxt_addr = stepped;
    endcase
  end
endmodule

// File: rtl/bag_beat_count.sv
module bag_beat_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  output logic             final_beat
);
  logic [LEN_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load)      left_d = load_len;
    else if (step) left_d = left_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (load || step)  left_q <= left_d;
  end

  assign final_beat = (left_q == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [1:0]        cmd_kind,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SIZE_W-1:0] size_q;
  burst_kind_e       kind_q;
  logic [ADDR_W-1:0] mask_q;
  burst_kind_e       dec_kind;
  logic [ADDR_W-1:0] dec_mask;
  logic [ADDR_W-1:0] adv_addr;
  logic              take_cmd, take_beat, advance, at_final;

  bag_cmd_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_dec (
    .kind_in(cmd_kind), .size_in(cmd_size), .len_in(cmd_len),
    .kind_eff(dec_kind), .fold_mask(dec_mask)
  );

  bag_next_addr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_nxt (
    .cur_addr(addr_q), .size_code(size_q), .kind(kind_q),
    .fold_mask(mask_q), .nxt_addr(adv_addr)
  );

  bag_beat_count #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(take_cmd), .load_len(cmd_len),
    .step(advance), .final_beat(at_final)
  );

  always_comb begin
    take_cmd  = cmd_valid && !busy_q;
    take_beat = busy_q && beat_ready;
    advance   = take_beat && !at_final;
    busy_d    = busy_q;
    addr_d    = addr_q;
    if (take_cmd) begin
      busy_d = 1'b1;
      addr_d = cmd_addr;
    end else if (take_beat) begin
      if (at_final) busy_d = 1'b0;
      else          addr_d = adv_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      kind_q <= KIND_FIXED;
      mask_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (take_cmd || advance) addr_q <= addr_d;
      if (take_cmd) begin
        size_q <= cmd_size;
        kind_q <= dec_kind;
        mask_q <= dec_mask;
      end
    end
  end

  assign cmd_ready  = !busy_q;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_last  = busy_q && at_final;
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        cmd_kind,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last
);
  logic [ADDR_W-1:0] start_q;
  logic              fixed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      fixed_q <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      start_q <= cmd_addr;
      fixed_q <= (cmd_kind == 2'b00);
    end
  end

  a_r1_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> cmd_ready);
  a_r2_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);
  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (beat_valid && beat_addr == $past(cmd_addr)));
  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> !beat_valid);
  a_r4_last_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
  a_r5_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && fixed_q) |-> beat_addr == start_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_last)));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_last(beat_last)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [2:0]  cmd_size;
  logic [7:0]  cmd_len;
  logic [1:0]  cmd_kind;
  logic        beat_valid;
  logic        beat_ready;
  logic [31:0] beat_addr;
  logic        beat_last;

  int checks;
  int fails;
  bit stall_mode;
  bit done;

  logic [31:0] q_addr[$];
  bit          q_last[$];
  string       q_tag[$];

  bit          prev_stall;
  logic [31:0] prev_addr;
  bit          prev_last;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_len(cmd_len),
    .cmd_kind(cmd_kind), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_last(beat_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected list of beats for one command.
  task automatic push_burst(input logic [31:0] a, input logic [2:0] sz,
                            input logic [7:0] ln, input logic [1:0] kd);
    longint bytes, beats, aligned, win, base, v;
    bit fold_ok;
    string tag;
    bytes   = longint'(1) << sz;
    beats   = longint'(ln) + 1;
    aligned = (longint'(a) / bytes) * bytes;
    fold_ok = (beats == 2) || (beats == 4) || (beats == 8) || (beats == 16);
    win     = bytes * beats;
    base    = (longint'(a) / win) * win;
    if (kd == 2'b00)               tag = "R5";
    else if (kd == 2'b11)          tag = "R9";
    else if (kd == 2'b10 && fold_ok) tag = "R7";
    else if (kd == 2'b10)          tag = "R8";
    else                           tag = "R6";
    for (longint i = 0; i < beats; i++) begin
      if (i == 0 || kd == 2'b00) v = longint'(a);
      else if (kd == 2'b10 && fold_ok) v = base + ((aligned - base + i * bytes) % win);
      else v = (aligned + i * bytes) & 64'hFFFF_FFFF;
      q_addr.push_back(v[31:0]);
      q_last.push_back(i == beats - 1);
      q_tag.push_back(i == 0 ? "R3" : tag);
    end
  endtask

  // Model and comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      q_addr.delete(); q_last.delete(); q_tag.delete();
      prev_stall = 1'b0;
      chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
      chk(beat_valid == 1'b0, "R1", "beat_valid in reset", beat_valid, 0);
    end else begin
      chk(cmd_ready == (q_addr.size() == 0), "R2", "cmd_ready",
          cmd_ready, q_addr.size() == 0);
      chk(beat_valid == (q_addr.size() != 0), "R4", "beat_valid",
          beat_valid, q_addr.size() != 0);
      if (q_addr.size() != 0) begin
        chk(beat_addr == q_addr[0], q_tag[0], "beat_addr", beat_addr, q_addr[0]);
        chk(beat_last == q_last[0], "R4", "beat_last", beat_last, q_last[0]);
        if (prev_stall) begin
          chk(beat_addr == prev_addr, "R10", "held addr", beat_addr, prev_addr);
          chk(beat_last == prev_last, "R10", "held last", beat_last, prev_last);
        end
        prev_stall = !beat_ready;
        prev_addr  = beat_addr;
        prev_last  = beat_last;
        if (beat_ready) begin
          void'(q_addr.pop_front()); void'(q_last.pop_front()); void'(q_tag.pop_front());
        end
      end else begin
        prev_stall = 1'b0;
        if (cmd_valid) push_burst(cmd_addr, cmd_size, cmd_len, cmd_kind);
      end
    end
  end

  // Back-pressure source.
  always @(posedge clk) begin
    #1 beat_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic send(input logic [31:0] a, input logic [2:0] sz,
                      input logic [7:0] ln, input logic [1:0] kd);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_addr = a; cmd_size = sz; cmd_len = ln; cmd_kind = kd;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (cmd_ready && q_addr.size() == 0) break;
    end
  endtask

  initial begin
    done = 1'b0;
    checks = 0; fails = 0;
    stall_mode = 1'b0;
    beat_ready = 1'b1;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_size = '0; cmd_len = '0; cmd_kind = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    send(32'h0000_1003, 3'd2, 8'd3, 2'b00); drain();            // R5 fixed
    send(32'h0000_1003, 3'd2, 8'd4, 2'b01); drain();            // R6 unaligned linear
    send(32'h0000_0038, 3'd2, 8'd3, 2'b10); drain();            // R7 4-beat fold
    send(32'h0000_01F8, 3'd3, 8'd7, 2'b10); drain();            // R7 8-beat fold
    send(32'h0000_0105, 3'd0, 8'd15, 2'b10); drain();           // R7 16-beat fold
    send(32'h0000_0020, 3'd2, 8'd2, 2'b10); drain();            // R8 illegal fold length
    send(32'h0000_0041, 3'd1, 8'd3, 2'b11); drain();            // R9 reserved kind
    send(32'h0000_0077, 3'd4, 8'd0, 2'b01); drain();            // R4 single beat
    send(32'hFFFF_FFF8, 3'd2, 8'd3, 2'b01); drain();            // R6 address roll-over
    // R2: second command waits through the whole first burst
    send(32'h0000_2000, 3'd3, 8'd5, 2'b01);
    send(32'h0000_3004, 3'd2, 8'd1, 2'b10); drain();
    // R10: random stalls under random commands
    stall_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      send($urandom, 3'($urandom % 8), 8'($urandom % 20), 2'($urandom % 4));
    end
    drain();
    stall_mode = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule